// File: doc/BRIEF.md
# Multi-Phase Oscillator Edge-Counting Quantizer

This block turns the free-running phase taps of a ring oscillator into a digital sample once per sampling window. Every phase tap passes through its own synchronizer and rising-edge detector in the system clock domain, and feeds its own edge counter. When the sampling strobe arrives, the per-phase counts are summed, limited to the output range and registered as one 10-bit word. A one-cycle valid pulse accompanies the word.

The oscillator is never reset. Only the counters restart at each strobe. An edge that has not yet been counted when a window closes is counted in the next window. The residue of one sample therefore carries into the next. This gives the output first-order shaping of the quantization error, and no edge is lost between windows. The sampling strobe is expected to pulse once every K reference periods. The expected sample is then about K times the number of phases times the ratio of oscillator frequency to reference frequency.

Top module: `vco_phase_quantizer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `sample_o` is 0 and `valid_o` is 0.
- R2: Each rising edge on a phase input is counted exactly once, provided each level of that input is held for at least one clock period. A new level first sampled at clock edge c is counted at clock edge c+2, because there are two synchronizer flops and an edge register.
- R3: When `sample_i` is high at clock edge S, `sample_o` takes the sum over all phases of the edges counted at edges before S and since the previous strobe. `valid_o` is high for exactly the one cycle after S.
- R4: The counters restart at each strobe. An edge counted at the strobe edge itself belongs to the new window. Without saturation, the total of all samples equals the total number of rising edges applied.
- R5: The summed result saturates at 1023 and never wraps.
- R6: Each per-phase counter saturates at 1023 within a window and does not wrap. After the next strobe it restarts from zero.
- R7: In any cycle not following a strobe, `valid_o` is 0 and `sample_o` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| phase_i | input | N_PHASES | Oscillator phase taps, asynchronous |
| sample_i | input | 1 | Sampling strobe, one cycle per window |
| sample_o | output | OUT_W | Summed, saturated edge count of the last window |
| valid_o | output | 1 | One-cycle pulse marking a new `sample_o` |

## Verification
The assertions assume that each phase tap holds every level for at least one system clock period. This keeps the edge detector from seeing two rising edges in consecutive cycles. They also assume that the strobe is a single-cycle pulse. The stimulus models each phase as a square wave whose half period is a whole number of clock cycles, at least one, with its own offset, and drives the strobe for one cycle only. The bench model replays the two-cycle detection delay to decide which window each edge belongs to. It includes edges that land exactly on a strobe.

// File: rtl/vpq_pkg.sv
package vpq_pkg;

   // Width of the per-window sum that holds n counters of cnt_w bits without loss
   function automatic int unsigned vpq_sum_width(int unsigned cnt_w, int unsigned n);
      return cnt_w + $clog2(n + 1);
   endfunction

endpackage

// File: rtl/vpq_edge_sync.sv
module vpq_edge_sync #(
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic rise_o
);
   localparam int unsigned LAST = SYNC_STAGES - 1;

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   initial begin
      assert (SYNC_STAGES >= 2) else $error("vpq_edge_sync: SYNC_STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], async_i};
         prev_q <= sync_q[LAST];
      end
   end

   assign rise_o = sync_q[LAST] & ~prev_q;

   // R2: a detected rise can never repeat in the next cycle
   p_edge_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise_o |=> !rise_o);

endmodule

// File: rtl/vpq_phase_counter.sv
module vpq_phase_counter #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             restart_i,
   output logic [CNT_W-1:0] count_o
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart_i) begin
         // an edge landing on the strobe opens the new window
         cnt_q <= CNT_W'(rise_i);
      end else if (rise_i && (cnt_q != {CNT_W{1'b1}})) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign count_o = cnt_q;

   // R4: right after a restart the window holds at most one edge
   p_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (count_o <= CNT_W'(1)));

   // R6: within a window the count never decreases (no wrap)
   p_no_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !restart_i |=> (count_o >= $past(count_o)));

endmodule

// File: rtl/vco_phase_quantizer.sv
module vco_phase_quantizer #(
   parameter int unsigned N_PHASES    = 4,
   parameter int unsigned OUT_W       = 10,
   parameter int unsigned CNT_W       = 10,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_PHASES-1:0] phase_i,
   input  logic                sample_i,
   output logic [OUT_W-1:0]    sample_o,
   output logic                valid_o
);
   import vpq_pkg::*;

   localparam int unsigned SUM_W = vpq_sum_width(CNT_W, N_PHASES);
   localparam logic [SUM_W-1:0] SAT_LIM = SUM_W'((64'd1 << OUT_W) - 64'd1);

   initial begin
      assert (N_PHASES >= 1) else $error("vco_phase_quantizer: need at least one phase");
      assert (SUM_W >= OUT_W) else $error("vco_phase_quantizer: sum narrower than output");
      assert (OUT_W <= 32) else $error("vco_phase_quantizer: OUT_W too wide");
   end

   logic [N_PHASES-1:0]            rise_w;
   logic [N_PHASES-1:0][CNT_W-1:0] cnt_w;
   logic [SUM_W-1:0]               sum_w;
   logic [OUT_W-1:0]               sat_w;
   logic [OUT_W-1:0]               sample_q;
   logic                           valid_q;

   for (genvar g = 0; g < N_PHASES; g++) begin : g_lane
      vpq_edge_sync #(
         .SYNC_STAGES (SYNC_STAGES)
      ) i_sync (
         .clk     (clk),
         .rst_n   (rst_n),
         .async_i (phase_i[g]),
         .rise_o  (rise_w[g])
      );

      vpq_phase_counter #(
         .CNT_W (CNT_W)
      ) i_cnt (
         .clk       (clk),
         .rst_n     (rst_n),
         .rise_i    (rise_w[g]),
         .restart_i (sample_i),
         .count_o   (cnt_w[g])
      );
   end

   always_comb begin
      sum_w = '0;
      for (int i = 0; i < N_PHASES; i++) begin
         sum_w = sum_w + SUM_W'(cnt_w[i]);
      end
   end

   assign sat_w = (sum_w > SAT_LIM) ? SAT_LIM[OUT_W-1:0] : sum_w[OUT_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= sample_i;
         if (sample_i) begin
            sample_q <= sat_w;
         end
      end
   end

   assign sample_o = sample_q;
   assign valid_o  = valid_q;

   // R3: each strobe yields a valid pulse in the following cycle
   p_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sample_i |=> valid_o);

   // R7: with no strobe the output word holds and valid stays low
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !sample_i |=> ($stable(sample_o) && !valid_o));

   // R5: a saturating sum from counters that only grow cannot shrink within a window
   p_sat_mono_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!sample_i && (sat_w == SAT_LIM[OUT_W-1:0])) |=> (sat_w == SAT_LIM[OUT_W-1:0]));

endmodule

// File: tb/test_vco_phase_quantizer.sv
module test_vco_phase_quantizer;
   localparam int CLK_PERIOD = 10;
   localparam int N = 4;
   localparam int OUT_MAX = 1023;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] phase_i = '0;
   logic         sample_i = 1'b0;
   logic [9:0]   sample_o;
   logic         valid_o;

   always #(CLK_PERIOD / 2) clk = ~clk;

   vco_phase_quantizer i_vco_phase_quantizer (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase_i  (phase_i),
      .sample_i (sample_i),
      .sample_o (sample_o),
      .valid_o  (valid_o)
   );

   int       checks = 0;
   int       failures = 0;
   int       hp[N];
   int       off[N];
   int       acc[N];
   int       cyc = 0;
   logic [N-1:0] prev_ph = '0, d1 = '0, d2 = '0;
   logic     exp_valid = 1'b0;
   int       exp_val = 0;
   string    tag = "R3";
   int       dut_total = 0;
   int       rise_total = 0;
   bit       tally_en = 1'b0;
   bit       done = 1'b0;

   function automatic int sat(int v);
      return (v > OUT_MAX) ? OUT_MAX : v;
   endfunction

   function automatic logic [N-1:0] gen_phases(int c);
      logic [N-1:0] p;
      for (int i = 0; i < N; i++) begin
         p[i] = (hp[i] == 0) ? 1'b0 : (((c + off[i]) / hp[i]) % 2 == 1);
      end
      return p;
   endfunction

   task automatic check(bit ok, string req, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic step(input logic smp);
      logic [N-1:0] ph, rises, adds;
      int s;
      @(negedge clk);
      if (exp_valid) begin
         check(valid_o === 1'b1, tag, int'(valid_o), 1);
         check(int'(sample_o) == exp_val, tag, int'(sample_o), exp_val);
         if (tally_en) dut_total += int'(sample_o);
      end else begin
         check(valid_o === 1'b0, "R7", int'(valid_o), 0);
         check(int'(sample_o) == exp_val, "R7", int'(sample_o), exp_val);
      end
      ph = gen_phases(cyc);
      cyc++;
      phase_i  = ph;
      sample_i = smp;
      rises = ph & ~prev_ph;
      prev_ph = ph;
      if (tally_en) rise_total += $countones(rises);
      adds = d2;
      d2 = d1;
      d1 = rises;
      if (smp) begin
         s = 0;
         for (int i = 0; i < N; i++) s += acc[i];
         exp_val = sat(s);
         exp_valid = 1'b1;
         for (int i = 0; i < N; i++) acc[i] = int'(adds[i]);
      end else begin
         exp_valid = 1'b0;
         for (int i = 0; i < N; i++) acc[i] = sat(acc[i] + int'(adds[i]));
      end
   endtask

   task automatic idle_all();
      for (int i = 0; i < N; i++) begin
         hp[i] = 0;
         off[i] = 0;
      end
   endtask

   // a single rise on phase 0 at the next step
   task automatic pulse0();
      hp[0]  = 1000;
      off[0] = 1000 - cyc;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int win;
      void'($urandom(32'd4711));
      idle_all();
      for (int i = 0; i < N; i++) acc[i] = 0;
      repeat (3) @(negedge clk);
      check(sample_o == 10'd0 && valid_o == 1'b0, "R1", int'(sample_o), 0);
      @(negedge clk);
      rst_n = 1'b1;
      check(sample_o == 10'd0 && valid_o == 1'b0, "R1", int'(sample_o), 0);

      // R1: first strobe after reset with idle phases gives zero
      tag = "R1";
      repeat (4) step(1'b0);
      step(1'b1);
      step(1'b0);

      // R2: one rise counted once
      tag = "R2";
      pulse0();
      repeat (6) step(1'b0);
      step(1'b1);
      hp[0] = 0;
      step(1'b0);

      // R4: rise counted on the strobe edge belongs to the new window
      tag = "R4";
      pulse0();
      step(1'b0);
      step(1'b0);
      step(1'b1);
      repeat (3) step(1'b0);
      step(1'b1);
      hp[0] = 0;
      step(1'b0);
      // rise counted one edge before the strobe stays in the old window
      pulse0();
      repeat (3) step(1'b0);
      step(1'b1);
      hp[0] = 0;
      repeat (4) step(1'b0);
      step(1'b1);
      step(1'b0);

      // R2, R3, R4: random phase rates and window lengths, edge conservation
      tag = "R2,R3";
      tally_en = 1'b1;
      for (int w = 0; w < 40; w++) begin
         for (int i = 0; i < N; i++) begin
            hp[i]  = ($urandom_range(0, 5) == 0) ? 0 : int'($urandom_range(1, 8));
            off[i] = int'($urandom_range(0, 15));
         end
         win = int'($urandom_range(5, 120));
         repeat (win) step(1'b0);
         step(1'b1);
      end
      idle_all();
      repeat (4) step(1'b0);
      step(1'b1);
      step(1'b0);
      tally_en = 1'b0;
      check(dut_total == rise_total, "R4", dut_total, rise_total);

      // R5: summed count beyond range saturates
      tag = "R5";
      for (int i = 0; i < N; i++) hp[i] = 1;
      repeat (700) step(1'b0);
      step(1'b1);
      step(1'b0);
      idle_all();
      repeat (4) step(1'b0);
      step(1'b1);
      step(1'b0);

      // R6: one phase alone over range saturates its counter, then restarts
      tag = "R6";
      hp[0] = 1;
      repeat (2500) step(1'b0);
      step(1'b1);
      repeat (20) step(1'b0);
      step(1'b1);
      step(1'b0);
      hp[0] = 0;
      step(1'b0);

      done = 1'b1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule